// File: doc/BRIEF.md
# Burst Data Mask Pipeline

This block sits on the data path of a burst memory controller and manages the per-beat mask input during read and write bursts. It accepts one command per clock (no-op, read, write, precharge), runs a burst of 1, 2 or 4 beats and tracks which beat is current. On a write burst the mask suppresses the commit of the beat captured on the same clock edge. On a read burst the mask travels down a two-stage pipe beside the read data and turns off the output driver when that beat reaches the pins. A masked beat still uses up its burst slot.

The block also decides how bursts end. A precharge ends any burst. A read or write command during a burst of the same kind restarts the beat count with no idle cycle. A read during a write switches over at once. A write during or just after a read is accepted only once enough masked or idle clocks have passed since the last read beat that drove the bus. An early write is ignored and reported on a one-cycle error strobe.

The controller has three states: IDLE, READ and WRITE. Its transitions are START_RD (any state to READ on a read command), START_WR (IDLE or READ to WRITE on an accepted write, or WRITE to WRITE as a restart), SWITCH_RD (WRITE to READ on a read command), STOP (READ or WRITE to IDLE on precharge) and DONE (READ or WRITE to IDLE after the last beat with no new command).

Top module: `burst_mask_pipe`

## Requirements
- R1: While reset is held and in the first cycle after it, burst_state_o is 0, rd_req_o, wr_en_o, rd_oe_o and cmd_err_o are 0, and rd_dq_o is 0.
- R2: cmd_i uses the encoding 0 no-op, 1 read, 2 write, 3 precharge. burst_state_o reads 0 IDLE, 1 READ, 2 WRITE, and rd_req_o is high exactly when the state is READ. bl_sel_i is latched when a command is accepted and selects the length: 0 gives 1 beat, 1 gives 2 beats, 2 or 3 gives 4 beats. The state returns to IDLE on the edge that ends the last beat.
- R3: For a write accepted on edge k, beat n is captured on edge k+1+n. In the following cycle wr_en_o is high, wr_data_o equals the wdata_i sampled on that edge and wr_beat_o equals n. If mask_i is high on that edge, wr_en_o is low instead.
- R4: A read beat sampled on edge e (rd_req_o high before e) appears in the cycle after edge e+1. rd_oe_o is then high and rd_dq_o carries the rdata_i sampled on e. If mask_i was high on e, rd_oe_o is low and rd_dq_o is 0.
- R5: beat_o advances by one on every burst edge whether or not the mask is high, so a burst of L beats lasts exactly L edges.
- R6: A read command during a read burst, a write command during a write burst, and a read command during a write burst each start a new burst at beat 0 on the next edge, with no idle cycle.
- R7: A precharge command puts the state in IDLE on the next edge and no further beats are issued.
- R8: A write command is accepted only when at least TURN_CYC edges have passed since the last read command or unmasked read beat, and the current edge is not an unmasked read beat. Otherwise it is ignored, the current burst continues, and cmd_err_o is high for the following cycle.
- R9: rd_oe_o is low and rd_dq_o is 0 in every cycle that carries no read beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 2 | Command: 0 no-op, 1 read, 2 write, 3 precharge |
| bl_sel_i | input | 2 | Burst length select, latched on accept |
| mask_i | input | 1 | Active-high beat mask, sampled on the edge |
| wdata_i | input | DATA_W | Write data for the current beat |
| rdata_i | input | DATA_W | Array read data for the current beat |
| rd_req_o | output | 1 | Read beat strobe to the array |
| wr_en_o | output | 1 | Commit the captured write beat |
| wr_data_o | output | DATA_W | Captured write data |
| wr_beat_o | output | BEAT_W | Beat index of the captured write |
| rd_dq_o | output | DATA_W | Read data toward the pins |
| rd_oe_o | output | 1 | Output driver enable |
| burst_state_o | output | 2 | Controller state code |
| beat_o | output | BEAT_W | Current beat index |
| cmd_err_o | output | 1 | Early write was rejected |

## Verification
The assertions assume cmd_i, bl_sel_i and mask_i are driven to known values once reset is released, and that cmd_i never carries anything outside its four codes. That holds because all four codes are defined. The bench changes every input only on falling edges. It draws commands from a weighted random mix with a fixed seed, so early writes, restarts and precharges in the middle of a burst all happen often. Directed runs put a masking phase ahead of a write so that the read-to-write turnaround is taken along its intended path.

// File: rtl/bmp_pkg.sv
package bmp_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_RD  = 2'd1,
        CMD_WR  = 2'd2,
        CMD_PRE = 2'd3
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } state_e;

    // Stages between the read sampling edge and the pins.
    localparam int RD_LAT = 2;

endpackage

// File: rtl/bmp_ctrl.sv
module bmp_ctrl
    import bmp_pkg::*;
#(
    parameter int MAX_LOG2 = 2,
    parameter int TURN_CYC = 3,
    parameter int BEAT_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_i,
    input  logic [1:0]        bl_sel_i,
    input  logic              mask_i,
    output state_e            state_o,
    output logic [BEAT_W-1:0] beat_o,
    output logic              rd_beat_o,
    output logic              wr_beat_o,
    output logic              err_o
);

    localparam int TA_W = $clog2(TURN_CYC + 1);

    cmd_e              cmd;
    state_e            st_q, st_d;
    logic [BEAT_W-1:0] beat_q, beat_d;
    logic [BEAT_W-1:0] last_q, last_d;
    logic [BEAT_W-1:0] new_last;
    logic [TA_W-1:0]   ta_q, ta_d;
    logic              err_q, err_d;
    logic              rd_beat, wr_beat, drive_beat, ta_ok;
    logic [1:0]        len_sel;

    assign cmd        = cmd_e'(cmd_i);
    assign rd_beat    = (st_q == ST_READ);
    assign wr_beat    = (st_q == ST_WRITE);
    assign drive_beat = rd_beat && !mask_i;
    assign ta_ok      = (ta_q == '0) && !drive_beat;

    always_comb begin
        if (int'(bl_sel_i) > MAX_LOG2) len_sel = 2'(MAX_LOG2);
        else                           len_sel = bl_sel_i;
        new_last = BEAT_W'((1 << len_sel) - 1);
    end

    // Turnaround counter: reloaded by any read activity that owns the bus.
    always_comb begin
        if (cmd == CMD_RD || drive_beat) ta_d = TA_W'(TURN_CYC);
        else if (ta_q != '0)             ta_d = ta_q - 1'b1;
        else                             ta_d = ta_q;
    end

    // Next state: burst continuation first, then command override.
    always_comb begin
        st_d   = st_q;
        beat_d = beat_q;
        last_d = last_q;
        err_d  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                beat_d = '0;
            end
            ST_READ, ST_WRITE: begin
                if (beat_q == last_q) begin      // DONE
                    st_d   = ST_IDLE;
                    beat_d = '0;
                end else begin
                    beat_d = beat_q + 1'b1;
                end
            end
            default: begin
                st_d   = ST_IDLE;
                beat_d = '0;
            end
        endcase
        unique case (cmd)
            CMD_NOP: ;
            CMD_RD: begin                        // START_RD / SWITCH_RD
                st_d   = ST_READ;
                beat_d = '0;
                last_d = new_last;
            end
            CMD_WR: begin
                if (ta_ok) begin                 // START_WR
                    st_d   = ST_WRITE;
                    beat_d = '0;
                    last_d = new_last;
                end else begin
                    err_d  = 1'b1;
                end
            end
            CMD_PRE: begin                       // STOP
                st_d   = ST_IDLE;
                beat_d = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            beat_q <= '0;
            last_q <= '0;
            ta_q   <= '0;
            err_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            beat_q <= beat_d;
            last_q <= last_d;
            ta_q   <= ta_d;
            err_q  <= err_d;
        end
    end

    always_comb begin
        state_o   = st_q;
        beat_o    = beat_q;
        rd_beat_o = rd_beat;
        wr_beat_o = wr_beat;
        err_o     = err_q;
    end

    a_r2_legal_state: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) || (st_q == ST_READ) || (st_q == ST_WRITE));

    a_r5_beat_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NOP && st_q != ST_IDLE && beat_q != last_q)
        |=> (beat_q == $past(beat_q) + 1'b1) && (st_q == $past(st_q)));

    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD) |=> (st_q == ST_READ) && (beat_q == '0));

    a_r7_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |=> (st_q == ST_IDLE));

    a_r8_early_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WR && drive_beat) |=> err_q && (st_q != ST_WRITE || $past(st_q) == ST_WRITE));

endmodule

// File: rtl/bmp_rd_pipe.sv
module bmp_rd_pipe
    import bmp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_i,
    input  logic              mask_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              oe_o
);

    logic              v_q [RD_LAT];
    logic              m_q [RD_LAT];
    logic [DATA_W-1:0] d_q [RD_LAT];

    for (genvar i = 0; i < RD_LAT; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v_q[0] <= 1'b0;
                    m_q[0] <= 1'b0;
                    d_q[0] <= '0;
                end else begin
                    v_q[0] <= beat_i;
                    m_q[0] <= mask_i;
                    d_q[0] <= data_i;
                end
            end
        end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v_q[i] <= 1'b0;
                    m_q[i] <= 1'b0;
                    d_q[i] <= '0;
                end else begin
                    v_q[i] <= v_q[i-1];
                    m_q[i] <= m_q[i-1];
                    d_q[i] <= d_q[i-1];
                end
            end
        end
    end

    always_comb begin
        oe_o = v_q[RD_LAT-1] && !m_q[RD_LAT-1];
        dq_o = oe_o ? d_q[RD_LAT-1] : '0;
    end

    a_r9_no_beat_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !v_q[RD_LAT-1] |-> !oe_o && (dq_o == '0));

endmodule

// File: rtl/bmp_wr_stage.sv
module bmp_wr_stage #(
    parameter int DATA_W = 8,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_i,
    input  logic              mask_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [BEAT_W-1:0] idx_i,
    output logic              en_o,
    output logic [DATA_W-1:0] data_o,
    output logic [BEAT_W-1:0] idx_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o   <= 1'b0;
            data_o <= '0;
            idx_o  <= '0;
        end else begin
            en_o <= beat_i && !mask_i;
            if (beat_i) begin
                data_o <= data_i;
                idx_o  <= idx_i;
            end
        end
    end

    a_r3_mask_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_i && mask_i) |=> !en_o);

    a_r3_unmasked_commits: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_i && !mask_i) |=> en_o && (idx_o == $past(idx_i)));

endmodule

// File: rtl/burst_mask_pipe.sv
module burst_mask_pipe
    import bmp_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int MAX_LOG2 = 2,
    parameter int TURN_CYC = 3,
    parameter int BEAT_W   = (MAX_LOG2 > 0) ? MAX_LOG2 : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_i,
    input  logic [1:0]        bl_sel_i,
    input  logic              mask_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              rd_req_o,
    output logic              wr_en_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [BEAT_W-1:0] wr_beat_o,
    output logic [DATA_W-1:0] rd_dq_o,
    output logic              rd_oe_o,
    output logic [1:0]        burst_state_o,
    output logic [BEAT_W-1:0] beat_o,
    output logic              cmd_err_o
);

    state_e st;
    logic   rd_beat, wr_beat;

    bmp_ctrl #(
        .MAX_LOG2 (MAX_LOG2),
        .TURN_CYC (TURN_CYC),
        .BEAT_W   (BEAT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_i     (cmd_i),
        .bl_sel_i  (bl_sel_i),
        .mask_i    (mask_i),
        .state_o   (st),
        .beat_o    (beat_o),
        .rd_beat_o (rd_beat),
        .wr_beat_o (wr_beat),
        .err_o     (cmd_err_o)
    );

    bmp_rd_pipe #(
        .DATA_W (DATA_W)
    ) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .beat_i (rd_beat),
        .mask_i (mask_i),
        .data_i (rdata_i),
        .dq_o   (rd_dq_o),
        .oe_o   (rd_oe_o)
    );

    bmp_wr_stage #(
        .DATA_W (DATA_W),
        .BEAT_W (BEAT_W)
    ) u_wr (
        .clk    (clk),
        .rst_n  (rst_n),
        .beat_i (wr_beat),
        .mask_i (mask_i),
        .data_i (wdata_i),
        .idx_i  (beat_o),
        .en_o   (wr_en_o),
        .data_o (wr_data_o),
        .idx_o  (wr_beat_o)
    );

    assign rd_req_o      = rd_beat;
    assign burst_state_o = st;

    a_r4_read_mask_delay: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe_o |-> $past(rd_beat, 2) && !$past(mask_i, 2));

    a_r8_no_write_over_read: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_o && rd_oe_o));

endmodule

// File: tb/burst_mask_pipe_tb.sv
module burst_mask_pipe_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW   = 8;
    localparam int BW   = 2;
    localparam int TURN = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cmd_i = '0;
    logic [1:0]    bl_sel_i = '0;
    logic          mask_i = 1'b0;
    logic [DW-1:0] wdata_i = '0;
    logic [DW-1:0] rdata_i = '0;
    logic          rd_req_o, wr_en_o, rd_oe_o, cmd_err_o;
    logic [DW-1:0] wr_data_o, rd_dq_o;
    logic [BW-1:0] wr_beat_o, beat_o;
    logic [1:0]    burst_state_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference state
    int m_st, m_beat, m_last, m_ta;
    int pv[2], pm[2], pd[2];
    int e_wen, e_wd, e_wb, e_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_mask_pipe #(.DATA_W(DW), .MAX_LOG2(2), .TURN_CYC(TURN), .BEAT_W(BW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .bl_sel_i(bl_sel_i),
        .mask_i(mask_i), .wdata_i(wdata_i), .rdata_i(rdata_i),
        .rd_req_o(rd_req_o), .wr_en_o(wr_en_o), .wr_data_o(wr_data_o),
        .wr_beat_o(wr_beat_o), .rd_dq_o(rd_dq_o), .rd_oe_o(rd_oe_o),
        .burst_state_o(burst_state_o), .beat_o(beat_o), .cmd_err_o(cmd_err_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int len_last(input int bl);
        int s = (bl > 2) ? 2 : bl;
        return (1 << s) - 1;
    endfunction

    task automatic model_reset();
        m_st = 0; m_beat = 0; m_last = 0; m_ta = 0;
        for (int i = 0; i < 2; i++) begin pv[i] = 0; pm[i] = 0; pd[i] = 0; end
        e_wen = 0; e_wd = 0; e_wb = 0; e_err = 0;
    endtask

    task automatic model_step(input int c, input int bl, input int m, input int wd, input int rd);
        int rdb = (m_st == 1) ? 1 : 0;
        int wrb = (m_st == 2) ? 1 : 0;
        int ok  = (m_ta == 0 && !(rdb == 1 && m == 0)) ? 1 : 0;
        int ns = m_st, nb = m_beat, nl = m_last;
        pv[1] = pv[0]; pm[1] = pm[0]; pd[1] = pd[0];
        pv[0] = rdb;   pm[0] = m;     pd[0] = rd;
        e_wen = (wrb == 1 && m == 0) ? 1 : 0;
        if (wrb == 1) begin e_wd = wd; e_wb = m_beat; end
        e_err = (c == 2 && ok == 0) ? 1 : 0;
        if (c == 1 || (rdb == 1 && m == 0)) m_ta = TURN;
        else if (m_ta > 0) m_ta--;
        if (m_st != 0) begin
            if (m_beat == m_last) begin ns = 0; nb = 0; end
            else nb = m_beat + 1;
        end
        if (c == 1) begin ns = 1; nb = 0; nl = len_last(bl); end
        else if (c == 2 && ok == 1) begin ns = 2; nb = 0; nl = len_last(bl); end
        else if (c == 3) begin ns = 0; nb = 0; end
        m_st = ns; m_beat = nb; m_last = nl;
    endtask

    task automatic compare();
        int eoe = (pv[1] == 1 && pm[1] == 0) ? 1 : 0;
        string rtag = (pv[1] == 1) ? "R4" : "R9";
        chk("R2", "burst_state", int'(burst_state_o), m_st);
        chk("R2", "rd_req", int'(rd_req_o), (m_st == 1) ? 1 : 0);
        chk("R5", "beat", int'(beat_o), m_beat);
        chk("R3", "wr_en", int'(wr_en_o), e_wen);
        if (e_wen == 1) begin
            chk("R3", "wr_data", int'(wr_data_o), e_wd);
            chk("R3", "wr_beat", int'(wr_beat_o), e_wb);
        end
        chk(rtag, "rd_oe", int'(rd_oe_o), eoe);
        chk(rtag, "rd_dq", int'(rd_dq_o), (eoe == 1) ? pd[1] : 0);
        chk("R8", "cmd_err", int'(cmd_err_o), e_err);
    endtask

    // Drive at a falling edge, cross one rising edge, check at the next falling edge.
    task automatic cyc(input int c, input int bl, input int m);
        int wd = int'($urandom_range(255, 0));
        int rd = int'($urandom_range(255, 0));
        cmd_i = c[1:0]; bl_sel_i = bl[1:0]; mask_i = m[0];
        wdata_i = wd[DW-1:0]; rdata_i = rd[DW-1:0];
        model_step(c, bl, m, wd, rd);
        @(negedge clk);
        compare();
    endtask

    initial begin
        void'($urandom(32'd20240613));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk("R1", "state in reset", int'(burst_state_o), 0);
        chk("R1", "wr_en in reset", int'(wr_en_o), 0);
        chk("R1", "rd_oe in reset", int'(rd_oe_o), 0);
        chk("R1", "err in reset", int'(cmd_err_o), 0);
        chk("R1", "rd_req in reset", int'(rd_req_o), 0);
        rst_n = 1'b1;
        cyc(0, 0, 0);
        chk("R1", "dq after reset", int'(rd_dq_o), 0);

        // write burst of 2: beat0 committed, beat1 masked
        cyc(2, 1, 0); cyc(0, 0, 0); cyc(0, 0, 1); cyc(0, 0, 0);
        // read burst of 2 with second beat masked, then drain
        cyc(1, 1, 0); cyc(0, 0, 0); cyc(0, 0, 1); cyc(0, 0, 0); cyc(0, 0, 0);
        // read restart mid-burst
        cyc(1, 2, 0); cyc(0, 0, 0); cyc(1, 1, 0);
        chk("R6", "read restart state", int'(burst_state_o), 1);
        chk("R6", "read restart beat", int'(beat_o), 0);
        // early write rejected, then mask phase, then write accepted
        cyc(2, 2, 0);
        chk("R8", "early write keeps read", int'(burst_state_o), 1);
        cyc(1, 2, 1); cyc(0, 0, 1); cyc(0, 0, 1); cyc(0, 0, 1);
        cyc(2, 2, 1);
        chk("R8", "write after turnaround", int'(burst_state_o), 2);
        // write restart, then switch to read
        cyc(0, 0, 0); cyc(2, 0, 0);
        chk("R6", "write restart beat", int'(beat_o), 0);
        cyc(1, 3, 0);
        chk("R6", "write to read state", int'(burst_state_o), 1);
        // precharge stops the read burst
        cyc(0, 0, 0); cyc(3, 0, 0);
        chk("R7", "precharge state", int'(burst_state_o), 0);
        cyc(0, 0, 0); cyc(0, 0, 0);
        chk("R7", "no beat after precharge", int'(rd_req_o), 0);
        // single-beat burst and clamp of bl_sel 3
        cyc(1, 0, 0); cyc(0, 0, 0);
        chk("R2", "single beat ends", int'(burst_state_o), 0);
        repeat (4) cyc(0, 0, 0);
        cyc(2, 3, 1); cyc(0, 0, 1); cyc(0, 0, 1);
        chk("R5", "masked beats advance", int'(beat_o), 2);
        cyc(0, 0, 1); cyc(0, 0, 0);

        // constrained random mix
        for (int k = 0; k < 3000; k++) begin
            int r = int'($urandom_range(99, 0));
            int c = (r < 66) ? 0 : (r < 78) ? 1 : (r < 92) ? 2 : 3;
            int m = ($urandom_range(99, 0) < 35) ? 1 : 0;
            cyc(c, int'($urandom_range(3, 0)), m);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule